// File: doc/BRIEF.md
# Converter Overcurrent Fault Qualifier

This block decides when a switching power converter must stop because of excess current, and when it may start again. It watches three separate conditions. The first is a fixed input-current comparator that arrives as a ready-made flag. The second is a programmable input overcurrent level, derived from the input current limit code. The third is a programmable battery discharge overcurrent level, derived from the discharge limit code. Each condition raises its own fault flag. The converter-disable output is asserted whenever any of the flags is set.

Each fault class follows its own timing policy. The fixed comparator fault tracks its flag with one register of delay and does not latch. The programmable input fault must hold through a blank-out window before it acts. Once the input current is back in range, it keeps the converter off for a long release window. The battery fault acts on the next clock edge and releases on the next clock edge. All windows are counted in ticks of an external 1 µs timebase.

The four configuration bits sit in a small register. That register takes new values only while a load strobe is high, and it comes out of reset with defined values.

Top module: `ocp_fault_qual`

## Requirements
- R1: While reset is high, and right after it, all flags and `conv_off` are 0. The configuration register resets to: input check off, input scale 200%, battery check on, battery scale 200%.
- R2: `flt_fixed` on each clock edge takes the value that `fixed_cmp_trip` had before that edge. It does not latch and does not depend on any configuration bit.
- R3: A scale bit of 0 selects floor(limit × 4 / 3) as the threshold, and a scale bit of 1 selects limit × 2. Thresholds are kept at full width, so no limit code can wrap them. A condition is present only when the sample is strictly greater than the threshold.
- R4: With the battery check enabled, `flt_bat` on each edge is 1 exactly when the battery sample before that edge exceeded the battery threshold.
- R5: The input overcurrent condition must stay present continuously. `flt_in` sets on the edge that counts the BLANK_TICKS-th tick after the cycle in which the condition was first seen. If the condition drops during this window, the count starts again.
- R6: After the input condition clears, `flt_in` stays set until RELEASE_TICKS further ticks have been counted. A ticked edge then clears it. If the condition returns during this window, the fault is held again and the release count starts again.
- R7: A disabled check never sets its flag. If a check is disabled while its flag is set, the flag clears on the second edge after the load strobe.
- R8: `conv_off` always equals the OR of `flt_fixed`, `flt_in` and `flt_bat`, in the same cycle.
- R9: The configuration inputs are captured only on an edge where `cfg_load` is 1. At other times, changes on them have no effect.
- R10: Both input windows advance only on edges where `tick_1us` is 1. Without ticks, a present input condition never sets `flt_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| fixed_cmp_trip | input | 1 | Fixed input-current comparator output |
| iin_sample | input | CUR_W | Input current sample code |
| iin_limit | input | CUR_W | Input current limit code |
| ibat_sample | input | CUR_W | Battery discharge current sample code |
| idchg_limit | input | CUR_W | Discharge current limit code |
| cfg_load | input | 1 | Load strobe for the configuration register |
| cfg_in_en | input | 1 | Enable for the programmable input check |
| cfg_in_sel | input | 1 | Input scale: 0 = 133%, 1 = 200% |
| cfg_bat_en | input | 1 | Enable for the battery discharge check |
| cfg_bat_sel | input | 1 | Battery scale: 0 = 133%, 1 = 200% |
| conv_off | output | 1 | Converter disable |
| flt_fixed | output | 1 | Fixed comparator fault |
| flt_in | output | 1 | Programmable input overcurrent fault |
| flt_bat | output | 1 | Battery discharge overcurrent fault |

## Verification
If the input qualifier's count or state is wrong, `flt_in` sets or clears one or more ticks away from the expected edge. The bench therefore checks the edge just before each expected change as well as the change itself. A wrong scale or compare width shows up in the very next cycle as a `flt_bat` error at the threshold boundary. The battery sweep covers every sample code against several limits, including the largest limit, whose doubled value needs the extra bit. A configuration register that loads without its strobe, or resets to the wrong values, shows at the flags within two cycles.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    IQ_IDLE    = 2'd0,
    IQ_BLANK   = 2'd1,
    IQ_HOLD    = 2'd2,
    IQ_RELEASE = 2'd3
  } iq_state_e;

  typedef struct packed {
    logic in_en;
    logic in_sel;
    logic bat_en;
    logic bat_sel;
  } ocp_cfg_t;

  localparam ocp_cfg_t CFG_RESET = '{in_en: 1'b0, in_sel: 1'b1, bat_en: 1'b1, bat_sel: 1'b1};

endpackage

// File: rtl/ocp_limit_scale.sv
module ocp_limit_scale #(
  parameter int CUR_W = 12
) (
  input  logic [CUR_W-1:0] sample,
  input  logic [CUR_W-1:0] limit,
  input  logic             sel_double,
  output logic             over
);
  localparam int TH_W = CUR_W + 2;

  logic [TH_W-1:0] quad;
  logic [TH_W-1:0] th_133;
  logic [TH_W-1:0] th_200;
  logic [TH_W-1:0] th_sel;

  always_comb begin
    quad   = {limit, 2'b00};
    th_133 = quad / TH_W'(3);
    th_200 = {1'b0, limit, 1'b0};
    th_sel = sel_double ? th_200 : th_133;
    over   = {2'b00, sample} > th_sel;
  end
endmodule

// File: rtl/ocp_in_qual.sv
module ocp_in_qual
  import ocp_pkg::*;
#(
  parameter int BLANK_TICKS   = 250,
  parameter int RELEASE_TICKS = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic over,
  input  logic tick,
  output logic fault_nxt
);
  localparam int MAX_T = (BLANK_TICKS > RELEASE_TICKS) ? BLANK_TICKS : RELEASE_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_TICKS - 1);
  localparam logic [CNT_W-1:0] REL_LAST   = CNT_W'(RELEASE_TICKS - 1);

  iq_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en) begin
      state_d = IQ_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        IQ_IDLE: begin
          if (over) begin
            state_d = IQ_BLANK;
            cnt_d   = '0;
          end
        end
        IQ_BLANK: begin
          if (!over) begin
            state_d = IQ_IDLE;
            cnt_d   = '0;
          end else if (tick) begin
            if (cnt_q == BLANK_LAST) begin
              state_d = IQ_HOLD;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        IQ_HOLD: begin
          if (!over) begin
            state_d = IQ_RELEASE;
            cnt_d   = '0;
          end
        end
        IQ_RELEASE: begin
          if (over) begin
            state_d = IQ_HOLD;
            cnt_d   = '0;
          end else if (tick) begin
            if (cnt_q == REL_LAST) begin
              state_d = IQ_IDLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          state_d = IQ_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= IQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign fault_nxt = (state_d == IQ_HOLD) || (state_d == IQ_RELEASE);
endmodule

// File: rtl/ocp_fault_qual.sv
module ocp_fault_qual
  import ocp_pkg::*;
#(
  parameter int CUR_W         = 12,
  parameter int BLANK_TICKS   = 250,
  parameter int RELEASE_TICKS = 250000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_1us,
  input  logic             fixed_cmp_trip,
  input  logic [CUR_W-1:0] iin_sample,
  input  logic [CUR_W-1:0] iin_limit,
  input  logic [CUR_W-1:0] ibat_sample,
  input  logic [CUR_W-1:0] idchg_limit,
  input  logic             cfg_load,
  input  logic             cfg_in_en,
  input  logic             cfg_in_sel,
  input  logic             cfg_bat_en,
  input  logic             cfg_bat_sel,
  output logic             conv_off,
  output logic             flt_fixed,
  output logic             flt_in,
  output logic             flt_bat
);
  ocp_cfg_t cfg_q;
  logic     in_over, bat_over;
  logic     in_fault_nxt, bat_fault_nxt, fixed_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_load) begin
      cfg_q <= '{in_en: cfg_in_en, in_sel: cfg_in_sel, bat_en: cfg_bat_en, bat_sel: cfg_bat_sel};
    end
  end

  ocp_limit_scale #(.CUR_W(CUR_W)) u_in_scale (
    .sample     (iin_sample),
    .limit      (iin_limit),
    .sel_double (cfg_q.in_sel),
    .over       (in_over)
  );

  ocp_limit_scale #(.CUR_W(CUR_W)) u_bat_scale (
    .sample     (ibat_sample),
    .limit      (idchg_limit),
    .sel_double (cfg_q.bat_sel),
    .over       (bat_over)
  );

  ocp_in_qual #(
    .BLANK_TICKS   (BLANK_TICKS),
    .RELEASE_TICKS (RELEASE_TICKS)
  ) u_in_qual (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_q.in_en),
    .over      (in_over),
    .tick      (tick_1us),
    .fault_nxt (in_fault_nxt)
  );

  assign bat_fault_nxt = cfg_q.bat_en & bat_over;
  assign fixed_nxt     = fixed_cmp_trip;

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_fixed <= 1'b0;
      flt_in    <= 1'b0;
      flt_bat   <= 1'b0;
      conv_off  <= 1'b0;
    end else begin
      flt_fixed <= fixed_nxt;
      flt_in    <= in_fault_nxt;
      flt_bat   <= bat_fault_nxt;
      conv_off  <= fixed_nxt | in_fault_nxt | bat_fault_nxt;
    end
  end
endmodule

// File: rtl/ocp_fault_qual_chk.sv
module ocp_fault_qual_chk (
  input logic clk,
  input logic rst,
  input logic tick_1us,
  input logic fixed_cmp_trip,
  input logic in_en_q,
  input logic bat_en_q,
  input logic conv_off,
  input logic flt_fixed,
  input logic flt_in,
  input logic flt_bat
);
  // R8
  conv_or_chk: assert property (@(posedge clk) disable iff (rst)
    conv_off == (flt_fixed | flt_in | flt_bat));

  // R2
  fixed_set_chk: assert property (@(posedge clk) disable iff (rst)
    fixed_cmp_trip |=> flt_fixed);

  // R2
  fixed_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !fixed_cmp_trip |=> !flt_fixed);

  // R7
  in_dis_chk: assert property (@(posedge clk) disable iff (rst)
    !in_en_q |=> !flt_in);

  // R7
  bat_dis_chk: assert property (@(posedge clk) disable iff (rst)
    !bat_en_q |=> !flt_bat);

  // R10
  in_rise_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flt_in) |-> $past(tick_1us));

  // R6
  in_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flt_in) |-> ($past(tick_1us) || !$past(in_en_q)));
endmodule

bind ocp_fault_qual ocp_fault_qual_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .tick_1us       (tick_1us),
  .fixed_cmp_trip (fixed_cmp_trip),
  .in_en_q        (cfg_q.in_en),
  .bat_en_q       (cfg_q.bat_en),
  .conv_off       (conv_off),
  .flt_fixed      (flt_fixed),
  .flt_in         (flt_in),
  .flt_bat        (flt_bat)
);

// File: tb/ocp_fault_qual_tb.sv
module ocp_fault_qual_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int BLK = 4;
  localparam int REL = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_1us = 1'b0;
  logic          fixed_cmp_trip = 1'b0;
  logic [CW-1:0] iin_sample = '0, iin_limit = '0, ibat_sample = '0, idchg_limit = '0;
  logic          cfg_load = 1'b0, cfg_in_en = 1'b0, cfg_in_sel = 1'b0;
  logic          cfg_bat_en = 1'b0, cfg_bat_sel = 1'b0;
  logic          conv_off, flt_fixed, flt_in, flt_bat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_fault_qual #(.CUR_W(CW), .BLANK_TICKS(BLK), .RELEASE_TICKS(REL)) u_dut (
    .clk(clk), .rst(rst), .tick_1us(tick_1us), .fixed_cmp_trip(fixed_cmp_trip),
    .iin_sample(iin_sample), .iin_limit(iin_limit), .ibat_sample(ibat_sample),
    .idchg_limit(idchg_limit), .cfg_load(cfg_load), .cfg_in_en(cfg_in_en),
    .cfg_in_sel(cfg_in_sel), .cfg_bat_en(cfg_bat_en), .cfg_bat_sel(cfg_bat_sel),
    .conv_off(conv_off), .flt_fixed(flt_fixed), .flt_in(flt_in), .flt_bat(flt_bat)
  );

  function automatic int thr(input int lim, input bit dbl);
    return dbl ? lim * 2 : (lim * 4) / 3;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic load_cfg(input bit ie, input bit is, input bit be, input bit bs);
    cfg_in_en = ie; cfg_in_sel = is; cfg_bat_en = be; cfg_bat_sel = bs;
    cfg_load = 1'b1;
    step(1);
    cfg_load = 1'b0;
  endtask

  // Raise input condition and confirm the blank window (R5).
  task automatic in_trip(input string tag);
    step(BLK);
    chk({tag, " R5 before blank end"}, flt_in, 0);
    step(1);
    chk({tag, " R5 blank end"}, flt_in, 1);
    chk({tag, " R8 conv_off"}, conv_off, 1);
  endtask

  // Condition removed just before: confirm release window (R6).
  task automatic in_release(input string tag);
    step(REL);
    chk({tag, " R6 before release end"}, flt_in, 1);
    step(1);
    chk({tag, " R6 release end"}, flt_in, 0);
  endtask

  initial begin
    #1;
    step(3);
    // R1 reset state
    chk("R1 flt_fixed", flt_fixed, 0);
    chk("R1 flt_in", flt_in, 0);
    chk("R1 flt_bat", flt_bat, 0);
    chk("R1 conv_off", conv_off, 0);
    rst = 1'b0;
    step(1);
    chk("R1 after reset conv_off", conv_off, 0);

    // R1 defaults: battery on at 200 %, input off
    idchg_limit = 8'd50; ibat_sample = 8'd101;
    step(1);
    chk("R1 R4 default bat on 200pct", flt_bat, 1);
    ibat_sample = 8'd100;
    step(1);
    chk("R1 R4 default bat at threshold", flt_bat, 0);
    iin_limit = 8'd0; iin_sample = 8'd255; tick_1us = 1'b1;
    step(BLK + 3);
    chk("R1 R7 default input off", flt_in, 0);
    iin_sample = 8'd0;

    // R2 fixed comparator follows, no latch
    fixed_cmp_trip = 1'b1;
    step(1);
    chk("R2 fixed set", flt_fixed, 1);
    chk("R8 conv_off fixed", conv_off, 1);
    fixed_cmp_trip = 1'b0;
    step(1);
    chk("R2 fixed release", flt_fixed, 0);
    chk("R8 conv_off clear", conv_off, 0);

    // R3 R4 battery sweep over all samples, both scales
    for (int s = 0; s < 2; s++) begin
      load_cfg(1'b0, 1'b1, 1'b1, s[0]);
      for (int li = 0; li < 8; li++) begin
        int lim;
        case (li)
          0: lim = 0;   1: lim = 1;   2: lim = 2;   3: lim = 3;
          4: lim = 7;   5: lim = 64;  6: lim = 127; default: lim = 255;
        endcase
        idchg_limit = lim[CW-1:0];
        for (int x = 0; x < 256; x++) begin
          ibat_sample = x[CW-1:0];
          step(1);
          chk("R3 R4 bat sweep", flt_bat, (x > thr(lim, s[0])) ? 1 : 0);
          chk("R8 bat sweep conv_off", conv_off, (x > thr(lim, s[0])) ? 1 : 0);
        end
      end
    end
    ibat_sample = 8'd0;
    step(1);

    // R3 R5 R6 input threshold boundary with ticks every cycle
    tick_1us = 1'b1;
    for (int s = 0; s < 2; s++) begin
      load_cfg(1'b1, s[0], 1'b0, 1'b1);
      for (int li = 0; li < 3; li++) begin
        int lim;
        lim = (li == 0) ? 3 : (li == 1) ? 30 : 90;
        iin_limit = lim[CW-1:0];
        iin_sample = 8'(thr(lim, s[0]));
        step(BLK + 3);
        chk("R3 input at threshold", flt_in, 0);
        iin_sample = 8'(thr(lim, s[0]) + 1);
        in_trip("R3 above threshold");
        iin_sample = 8'd0;
        in_release("R6 normal");
      end
    end

    // R5 drop during blank restarts the window
    load_cfg(1'b1, 1'b1, 1'b0, 1'b1);
    iin_limit = 8'd10; iin_sample = 8'd30;
    step(BLK);
    chk("R5 partial blank", flt_in, 0);
    iin_sample = 8'd0;
    step(1);
    iin_sample = 8'd30;
    in_trip("R5 restart");

    // R6 return during release restarts it
    iin_sample = 8'd0;
    step(REL - 2);
    chk("R6 partial release", flt_in, 1);
    iin_sample = 8'd30;
    step(1);
    chk("R6 held again", flt_in, 1);
    iin_sample = 8'd0;
    in_release("R6 restart");

    // R10 no ticks, no fault
    tick_1us = 1'b0;
    iin_sample = 8'd30;
    step(3 * BLK);
    chk("R10 no ticks", flt_in, 0);
    tick_1us = 1'b1;
    step(BLK - 1);
    chk("R10 ticks resume before end", flt_in, 0);
    step(1);
    chk("R10 ticks resume end", flt_in, 1);

    // R7 clearing input enable while fault active
    load_cfg(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7 load edge keeps input fault", flt_in, 1);
    step(1);
    chk("R7 input cleared", flt_in, 0);
    chk("R7 R8 conv_off cleared", conv_off, 0);
    iin_sample = 8'd0;

    // R9 config ignored without load; R8 OR of several faults
    load_cfg(1'b0, 1'b1, 1'b1, 1'b1);
    idchg_limit = 8'd20; ibat_sample = 8'd60;
    fixed_cmp_trip = 1'b1;
    step(1);
    chk("R4 bat fault", flt_bat, 1);
    fixed_cmp_trip = 1'b0;
    cfg_bat_en = 1'b0; cfg_bat_sel = 1'b1;
    step(3);
    chk("R9 no load bat still set", flt_bat, 1);
    chk("R8 conv_off from bat only", conv_off, 1);
    chk("R2 fixed clear", flt_fixed, 0);
    load_cfg(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7 bat load edge", flt_bat, 1);
    step(1);
    chk("R7 bat cleared", flt_bat, 0);
    chk("R8 conv_off all clear", conv_off, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule